// File: doc/BRIEF.md
# Three-Wire Radio Register Serial Master

This block reads and writes the 12-bit registers of an external radio transceiver through a bit-banged serial link. The link uses a framing enable (idle high), a serial clock, a data line whose output driver can be released, an auxiliary control line used only during reads, and a returned data line from the radio. The host presents one request at a time. Each request carries a direction flag, a 4-bit register index and, for writes, 12 bits of data. The block raises `busy` while it works. It ends every transaction with a one-cycle `done`, and for reads `rdata` then holds the returned value.

All pin timing is built from one time unit, the step, which lasts `STEP_CYCLES` system clocks. The enable guard intervals last `GUARD_STEPS` steps. Bits alternate between two shapes. In a "leading" bit the data is set while the clock is low for one step, and then the clock is high for two steps. In a "trailing" bit the clock is high for two steps with the new data, and then low for one step. A frame always starts with a leading bit. As a result, every clock edge in the address or data phase, rising or falling, carries exactly one bit.

Top module: `rf3w_master`

## Requirements
- R1: After reset and while idle, `rf_en`=1, `rf_clk`=0, `rf_doe`=0, `rf_aux`=0, `busy`=0 and `done`=0.
- R2: A write sends the 16-bit word {data[11:0], index[3:0]}, most significant bit first. The bits alternate leading and trailing, starting with leading, so each of the 16 clock edges seen with `rf_doe`=1 and `rf_aux`=0 carries one bit, and `rf_dout` is stable across every such edge.
- R3: After a request is accepted, `rf_en` stays high for GUARD_STEPS steps and then goes low for GUARD_STEPS steps before the first bit. A write closes with `rf_en` high for GUARD_STEPS steps before `done`. `rf_en` only rises while `rf_clk` is low.
- R4: A read sends the 5-bit address {1'b0, index[3:0]}, most significant bit first, on 5 clock edges using the same alternating bit shapes.
- R5: After the read address, `rf_clk` and `rf_aux` are high together for one step. Then `rf_aux` alone is high for two steps, with `rf_doe` still 1. After that, `rf_doe` stays 0 until the transaction ends.
- R6: A read then takes 12 bits, most significant first. For each bit, `rf_clk` is high for exactly 3 steps with `rf_aux` high and `rf_doe` low. The bit is the two-flop-synchronised `rf_din`, sampled at the end of the high time. The 12-bit result appears on `rdata` with `done` and is held there.
- R7: A read closes with `rf_en` and `rf_aux` high together for one step, and then all pins return to the idle levels of R1.
- R8: `busy` is high from the cycle after a request is accepted until `done`. `done` is a single-cycle pulse in the first idle cycle. A request raised while `busy` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 4 | Radio register index |
| req_wdata | input | 12 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 12 | Last read result |
| rf_en | output | 1 | Framing enable, idle high |
| rf_clk | output | 1 | Serial clock |
| rf_dout | output | 1 | Serial data to the radio |
| rf_doe | output | 1 | Output enable for the data pin |
| rf_aux | output | 1 | Auxiliary control line for reads |
| rf_din | input | 1 | Serial data from the radio |

## Verification
A wrong bit counter or a wrong leading/trailing flag changes the number of clock edges in the frame, or shifts the bit order. The bench's radio model therefore decodes a wrong register, or a frame of the wrong length, as soon as `rf_en` rises or `rf_aux` first goes high. A wrong phase length shows up within a single transaction, because the measured setup, close, turnaround and read-clock-high intervals no longer equal their step multiples. A wrong sampling point or a broken synchroniser corrupts `rdata`, and the corruption is visible at the `done` that ends that same read.

// File: rtl/rf3w_master.sv
module rf3w_master #(
  parameter int STEP_CYCLES = 4,
  parameter int GUARD_STEPS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [3:0]  req_index,
  input  logic [11:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic [11:0] rdata,
  output logic        rf_en,
  output logic        rf_clk,
  output logic        rf_dout,
  output logic        rf_doe,
  output logic        rf_aux,
  input  logic        rf_din
);

  localparam int MAXLEN = (GUARD_STEPS > 3) ? GUARD_STEPS : 3;
  localparam int LW = $clog2(MAXLEN + 1);
  localparam int DW = $clog2(STEP_CYCLES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_OPEN, S_PRE, S_HIGH, S_POST,
    S_TURN1, S_TURN2, S_RHIGH, S_RLOW, S_RCLOSE, S_CLOSE
  } st_t;

  st_t         st, nst;
  int          nlen;
  logic [DW-1:0] div;
  logic [LW-1:0] left;
  logic [3:0]  pos, rcnt;
  logic        lead, wr;
  logic [15:0] sh;
  logic [1:0]  sync;
  logic        tick, pend, last_bit;

  assign tick     = (div == DW'(STEP_CYCLES - 1));
  assign pend     = tick && (left == '0);
  assign last_bit = (pos == 4'd0);

  always_comb begin
    nst  = S_IDLE;
    nlen = 1;
    case (st)
      S_SETUP: begin nst = S_OPEN; nlen = GUARD_STEPS; end
      S_OPEN:  begin nst = S_PRE;  nlen = 1; end
      S_PRE:   begin nst = S_HIGH; nlen = 2; end
      S_HIGH:
        if (!lead)         begin nst = S_POST; nlen = 1; end
        else if (!last_bit) begin nst = S_HIGH; nlen = 2; end
        else if (wr)       begin nst = S_CLOSE; nlen = GUARD_STEPS; end
        else               begin nst = S_TURN1; nlen = 1; end
      S_POST:
        if (!last_bit)     begin nst = S_PRE; nlen = 1; end
        else if (wr)       begin nst = S_CLOSE; nlen = GUARD_STEPS; end
        else               begin nst = S_TURN1; nlen = 1; end
      S_TURN1: begin nst = S_TURN2; nlen = 2; end
      S_TURN2: begin nst = S_RHIGH; nlen = 3; end
      S_RHIGH: begin nst = S_RLOW;  nlen = 1; end
      S_RLOW:
        if (rcnt == 4'd0)  begin nst = S_RCLOSE; nlen = 1; end
        else               begin nst = S_RHIGH;  nlen = 3; end
      default: begin nst = S_IDLE; nlen = 1; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= '0;
    end else begin
      sync <= {sync[0], rf_din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      div   <= '0;
      left  <= '0;
      pos   <= '0;
      rcnt  <= '0;
      lead  <= 1'b0;
      wr    <= 1'b0;
      sh    <= '0;
      done  <= 1'b0;
      rdata <= '0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        div <= '0;
        if (req_valid) begin
          st   <= S_SETUP;
          left <= LW'(GUARD_STEPS - 1);
          wr   <= req_write;
          sh   <= req_write ? {req_wdata, req_index} : {1'b0, req_index, 11'd0};
          pos  <= req_write ? 4'd15 : 4'd4;
          lead <= 1'b1;
          rcnt <= 4'd11;
        end
      end else begin
        div <= tick ? '0 : div + 1'b1;
        if (tick && left != '0) left <= left - 1'b1;
        if (pend) begin
          st   <= nst;
          left <= LW'(nlen - 1);
          if (((st == S_HIGH && lead) || st == S_POST) && !last_bit) begin
            pos  <= pos - 1'b1;
            sh   <= {sh[14:0], 1'b0};
            lead <= !lead;
          end
          if (st == S_RHIGH) rdata <= {rdata[10:0], sync[1]};
          if (st == S_RLOW && rcnt != 4'd0) rcnt <= rcnt - 1'b1;
          if (st == S_CLOSE || st == S_RCLOSE) done <= 1'b1;
        end
      end
    end
  end

  assign busy    = (st != S_IDLE);
  assign rf_en   = st inside {S_IDLE, S_SETUP, S_CLOSE, S_RCLOSE};
  assign rf_clk  = st inside {S_HIGH, S_TURN1, S_RHIGH};
  assign rf_dout = (st inside {S_PRE, S_HIGH, S_POST}) && sh[15];
  assign rf_doe  = st inside {S_SETUP, S_OPEN, S_PRE, S_HIGH, S_POST, S_TURN1, S_TURN2, S_CLOSE};
  assign rf_aux  = st inside {S_TURN1, S_TURN2, S_RHIGH, S_RLOW, S_RCLOSE};

  assert_data_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_doe && !rf_aux && (rf_clk != $past(rf_clk))) |-> (rf_dout == $past(rf_dout)));
  assert_en_rise_clk_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rf_en) |-> !rf_clk);
  assert_released_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rf_clk) && rf_aux) |-> !rf_doe);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_ends_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_done_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rf_en && !rf_doe && !rf_aux && !rf_clk));

endmodule

// File: tb/sim_rf3w_master.sv
module sim_rf3w_master;
  localparam int CLK_PERIOD = 10;
  localparam int STEP = 4;
  localparam int GUARD = 3;

  typedef struct packed {
    logic        rd;
    logic [3:0]  idx;
    logic [11:0] val;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [3:0] req_index = 0;
  logic [11:0] req_wdata = 0;
  logic busy, done, rf_en, rf_clk, rf_dout, rf_doe, rf_aux;
  logic [11:0] rdata;
  logic rf_din;

  int total = 0, bad = 0, cyc = 0;
  item_t fq[$];
  item_t rq[$];
  logic [11:0] shadow [16];

  rf3w_master #(.STEP_CYCLES(STEP), .GUARD_STEPS(GUARD)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_index(req_index), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .rf_en(rf_en), .rf_clk(rf_clk), .rf_dout(rf_dout),
    .rf_doe(rf_doe), .rf_aux(rf_aux), .rf_din(rf_din));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // radio model and monitor
  logic [11:0] regs [16];
  logic p_en, p_clk, p_aux, p_done, in_frame, is_rd, seen_open;
  int fcnt, setup_c, close_c, t1_c, t2_c, hrun;
  logic [15:0] fsh;
  logic [11:0] rd_sh;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) regs[i] = 12'(i * 273 + 5);
      rf_din <= 1'b0;
      p_en = 1; p_clk = 0; p_aux = 0; p_done = 0;
      in_frame = 0; is_rd = 0; seen_open = 0;
      fcnt = 0; fsh = 0; setup_c = 0; close_c = 0; t1_c = 0; t2_c = 0; hrun = 0; rd_sh = 0;
    end else begin
      if (p_en && !rf_en) begin
        in_frame = 1; fcnt = 0; fsh = 0; is_rd = 0; seen_open = 1;
      end
      if (in_frame && !rf_en && rf_doe && !rf_aux && (rf_clk != p_clk)) begin
        fsh = {fsh[14:0], rf_dout}; fcnt++;
      end
      if (in_frame && rf_aux && !p_aux) begin
        item_t e;
        is_rd = 1;
        if (fq.size() == 0) chk(0, "R8 unexpected read frame", fsh, 0);
        else begin
          e = fq.pop_front();
          chk(e.rd == 1'b1, "R4 frame kind", 0, 1);
          chk(fcnt == 5, "R4 address edge count", fcnt, 5);
          chk(fsh[4:0] == {1'b0, e.idx}, "R4 address bits", fsh[4:0], {1'b0, e.idx});
        end
        rd_sh = regs[fsh[3:0]];
      end
      if (is_rd && rf_clk && !p_clk && rf_aux && !rf_doe) begin
        rf_din <= rd_sh[11];
        rd_sh = {rd_sh[10:0], 1'b0};
      end
      if (in_frame && rf_en && !p_en) begin
        in_frame = 0;
        if (!is_rd) begin
          item_t e;
          if (fq.size() == 0) chk(0, "R8 unexpected write frame", fsh, 0);
          else begin
            e = fq.pop_front();
            chk(e.rd == 1'b0, "R2 frame kind", 1, 0);
            chk(fcnt == 16, "R2 write edge count", fcnt, 16);
            chk(fsh == {e.val, e.idx}, "R2 write word", fsh, {e.val, e.idx});
          end
          regs[fsh[3:0]] = fsh[15:4];
        end
      end
      if (busy && rf_en && !seen_open) setup_c++;
      if (busy && rf_en && seen_open) close_c++;
      if (rf_aux && rf_clk && rf_doe) t1_c++;
      if (rf_aux && !rf_clk && rf_doe) t2_c++;
      if (rf_clk && rf_aux && !rf_doe) hrun++;
      else if (hrun != 0) begin
        chk(hrun == 3 * STEP, "R6 read clock high length", hrun, 3 * STEP);
        hrun = 0;
      end
      if (p_done) chk(!done, "R8 done single cycle", done, 0);
      if (done) begin
        item_t e;
        chk(!busy && rf_en && !rf_doe && !rf_aux && !rf_clk, "R7 idle pins at done",
            {busy, rf_en, rf_doe, rf_aux, rf_clk}, 5'b01000);
        chk(setup_c == GUARD * STEP, "R3 setup guard", setup_c, GUARD * STEP);
        if (rq.size() == 0) chk(0, "R8 unexpected done", 0, 1);
        else begin
          e = rq.pop_front();
          if (e.rd) begin
            chk(close_c == STEP, "R7 read close length", close_c, STEP);
            chk(t1_c == STEP, "R5 turnaround clock+aux", t1_c, STEP);
            chk(t2_c == 2 * STEP, "R5 turnaround aux only", t2_c, 2 * STEP);
            chk(rdata == e.val, "R6 read data", rdata, e.val);
          end else begin
            chk(close_c == GUARD * STEP, "R3 write close guard", close_c, GUARD * STEP);
          end
        end
        setup_c = 0; close_c = 0; t1_c = 0; t2_c = 0; seen_open = 0;
      end
      p_en = rf_en; p_clk = rf_clk; p_aux = rf_aux; p_done = done;
    end
  end

  task automatic issue(input bit rd, input logic [3:0] idx, input logic [11:0] val, input bit poke);
    item_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    e.rd = rd; e.idx = idx; e.val = rd ? shadow[idx] : val;
    fq.push_back(e);
    rq.push_back(e);
    if (!rd) shadow[idx] = val;
    req_valid = 1; req_write = !rd; req_index = idx; req_wdata = val;
    @(negedge clk);
    req_valid = 0;
    chk(busy, "R8 busy after accept", busy, 1);
    if (poke) begin
      repeat (30) @(negedge clk);
      req_valid = 1; req_write = 1; req_index = idx; req_wdata = ~val;
      @(negedge clk);
      req_valid = 0;
    end
    while (!done) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) shadow[i] = 12'(i * 273 + 5);
    repeat (3) @(negedge clk);
    chk(rf_en && !rf_clk && !rf_doe && !rf_aux && !busy && !done, "R1 reset levels",
        {rf_en, rf_clk, rf_doe, rf_aux, busy, done}, 6'b100000);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(rf_en && !rf_clk && !rf_doe && !rf_aux && !busy, "R1 idle levels",
        {rf_en, rf_clk, rf_doe, rf_aux, busy}, 5'b10000);
    issue(0, 4'd3, 12'habc, 0);
    issue(0, 4'd0, 12'h001, 0);
    issue(0, 4'd15, 12'hfff, 0);
    issue(0, 4'd8, 12'h800, 0);
    issue(0, 4'd5, 12'h555, 0);
    issue(1, 4'd3, 0, 0);
    issue(1, 4'd0, 0, 0);
    issue(1, 4'd15, 0, 0);
    issue(1, 4'd8, 0, 0);
    issue(1, 4'd5, 0, 0);
    issue(1, 4'd7, 0, 0);
    issue(1, 4'd10, 0, 0);
    issue(0, 4'd2, 12'h123, 1);
    issue(1, 4'd2, 0, 1);
    issue(1, 4'd2, 0, 0);
    repeat (20) @(negedge clk);
    chk(fq.size() == 0 && rq.size() == 0, "R8 no pending items", fq.size() + rq.size(), 0);
    chk(rdata == 12'h123, "R6 rdata held", rdata, 12'h123);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule